// File: doc/BRIEF.md
# Link and Receive Activity Indicator with Serial Status Output

This block drives one status indicator for each of eight twisted-pair ports and shifts all eight onto a single serial pin. The indicator shows two things. When a port has no link, its indicator is high. When the link is good and the port is quiet, the indicator is low. When a packet arrives on a port with a good link, the indicator goes high for a fixed blink period. It then stays dark for a minimum hold-off period, and only after that can a new packet raise it again.

Each port has a small three-state machine with states idle, blink and hold-off, and one down-counter. The blink and hold-off lengths are parameters counted in system clock cycles. The defaults give 78 ms and 52 ms at 25 MHz; a bench can use much shorter values.

A serializer watches an external shift clock, which it synchronises into the system clock domain. On each falling edge of the shift clock it presents the next bit. At the first falling edge of a frame it takes a snapshot of all eight indicator levels, so one frame always carries one consistent picture. An external shift register turns the stream back into parallel form.

Top module: `link_activity_indicator`

## Requirements
- R1: A port whose link flag is 0 shows indicator level 1, whatever its receive activity.
- R2: A port whose link flag is 1 and that is not blinking shows indicator level 0.
- R3: A receive pulse sampled on a clock edge while the port is idle with link good makes the indicator 1 from that edge for exactly ON_CYC clock cycles.
- R4: After the blink, the indicator is 0 for OFF_CYC cycles. Receive pulses that arrive during the blink or the hold-off are dropped: they neither extend the blink nor start one later.
- R5: A receive pulse that arrives once the hold-off has ended starts a new blink.
- R6: A link loss ends any blink or hold-off and returns the port to idle. A pulse after the link comes back starts a blink at once.
- R7: Each falling edge of the shift clock moves the serial output to the next bit of an 8-bit frame, LSB first, with bit k equal to port k's indicator level. Between falling edges the serial output holds its value.
- R8: The frame is sampled at its first falling edge (bit 0). Indicator changes later in that frame appear only in the next frame.
- R9: Synchronous active-low reset returns every port to idle, clears the serial output to 0 and restarts the frame at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_ok | input | 8 | Link-good flag per port, 1 = link pass |
| rx_pulse | input | 8 | Packet-received pulse per port, one cycle |
| shift_clk | input | 1 | External shift clock, asynchronous to clk |
| status_sdo | output | 1 | Serial status data, updated after each shift-clock falling edge |
| port_led | output | 8 | Per-port indicator level, 1 = lit or link failed |

## Verification
On every cycle, the assertions check how each port's state machine moves. An idle port with link and a pulse enters the blink with a full count. An expiring blink always passes into hold-off. A hold-off never goes straight back to blink. A lost link always leads to idle. They also check that the serial output and the bit index stay put between shift-clock falling edges, and that bit 0 comes from the snapshot. Only the bench scenarios can show the exact blink and hold-off lengths seen at the ports. The same is true of dropped pulses that leave no later trace, the bit-for-bit order of whole frames, and the snapshot ignoring changes made in the middle of a frame.

// File: rtl/link_activity_pkg.sv
package link_activity_pkg;
    // Per-port indicator state machine states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BLINK = 2'd1,
        ST_HOLDOFF = 2'd2
    } blink_state_t;
endpackage

// File: rtl/port_blink_cell.sv
// port_blink_cell: stretches one port's receive pulse into a blink of ON_CYC
// cycles, then enforces an OFF_CYC dark period. A link loss forces the output
// high and returns the cell to idle.
// Assumes: rx_pulse is synchronous to clk; ON_CYC and OFF_CYC are >= 1.
module port_blink_cell
    import link_activity_pkg::*;
#(
    parameter int ON_CYC  = 1950000,
    parameter int OFF_CYC = 1300000,
    parameter int CNT_W   = 21
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_ok,
    input  logic rx_pulse,
    output logic led
);
    blink_state_t state;
    logic [CNT_W-1:0] cnt;

    // State and counter update for the blink/hold-off sequence
    always_ff @(posedge clk) begin
        if (!rst_n || !link_ok) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (rx_pulse) begin
                    state <= ST_BLINK;
                    cnt   <= CNT_W'(ON_CYC - 1);
                end
                ST_BLINK: if (cnt == '0) begin
                    state <= ST_HOLDOFF;
                    cnt   <= CNT_W'(OFF_CYC - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                ST_HOLDOFF: if (cnt == '0) begin
                    state <= ST_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Indicator: high on link failure or while blinking
    always_comb led = !link_ok || (state == ST_BLINK);

    assert_idle_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && link_ok && rx_pulse) |=>
            (state == ST_BLINK && cnt == CNT_W'(ON_CYC - 1)));

    assert_blink_to_holdoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLINK && cnt == '0 && link_ok) |=> (state == ST_HOLDOFF));

    assert_holdoff_no_retrigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLDOFF) |=> (state != ST_BLINK));

    assert_linkloss_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_ok) |=> (state == ST_IDLE));
endmodule

// File: rtl/status_serializer.sv
// status_serializer: synchronises an external shift clock, and on each of its
// falling edges presents the next bit of an NBITS frame, LSB first. The frame
// is a snapshot of par_in taken at bit 0.
// Assumes: the shift clock is slower than a few system clock periods.
module status_serializer #(
    parameter int NBITS = 8,
    parameter int IDX_W = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_clk,
    input  logic [NBITS-1:0] par_in,
    output logic             sdo
);
    logic sc_meta, sc_sync, sc_prev;
    logic fall;
    logic [IDX_W-1:0] bit_idx;
    logic [NBITS-1:0] frame_q;

    // Two-flop synchroniser plus delay stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_meta <= 1'b1;
            sc_sync <= 1'b1;
            sc_prev <= 1'b1;
        end else begin
            sc_meta <= shift_clk;
            sc_sync <= sc_meta;
            sc_prev <= sc_sync;
        end
    end

    // Falling edge of the synchronised shift clock
    always_comb fall = sc_prev && !sc_sync;

    // Frame snapshot, bit index and serial output update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx <= '0;
            frame_q <= '0;
            sdo     <= 1'b0;
        end else if (fall) begin
            if (bit_idx == '0) begin
                frame_q <= par_in;
                sdo     <= par_in[0];
            end else begin
                sdo <= frame_q[bit_idx];
            end
            bit_idx <= (bit_idx == IDX_W'(NBITS - 1)) ? '0 : bit_idx + 1'b1;
        end
    end

    assert_hold_between_edges_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall) |=> ($stable(sdo) && $stable(bit_idx)));

    assert_snapshot_bit0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && bit_idx == '0) |=> (sdo == $past(par_in[0]) && frame_q == $past(par_in)));
endmodule

// File: rtl/link_activity_indicator.sv
// link_activity_indicator: eight per-port link/activity indicators combined
// into one serial status stream.
// Assumes: durations are given in clk cycles; shift_clk is asynchronous.
module link_activity_indicator #(
    parameter int NPORT   = 8,
    parameter int ON_CYC  = 1950000,
    parameter int OFF_CYC = 1300000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] link_ok,
    input  logic [NPORT-1:0] rx_pulse,
    input  logic             shift_clk,
    output logic             status_sdo,
    output logic [NPORT-1:0] port_led
);
    localparam int MAX_CYC = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    // One stretcher cell per port
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        port_blink_cell #(
            .ON_CYC (ON_CYC),
            .OFF_CYC(OFF_CYC),
            .CNT_W  (CNT_W)
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .link_ok (link_ok[p]),
            .rx_pulse(rx_pulse[p]),
            .led     (port_led[p])
        );
    end

    status_serializer #(
        .NBITS(NPORT)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_clk(shift_clk),
        .par_in   (port_led),
        .sdo      (status_sdo)
    );
endmodule

// File: tb/link_activity_indicator_test.sv
module link_activity_indicator_test;
    localparam int CLK_PERIOD = 10;
    localparam int ON_C  = 10;
    localparam int OFF_C = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] link_ok = 8'hFF;
    logic [7:0] rx_pulse = 8'h00;
    logic shift_clk = 1'b1;
    logic status_sdo;
    logic [7:0] port_led;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    link_activity_indicator #(.NPORT(8), .ON_CYC(ON_C), .OFF_CYC(OFF_C)) uut (
        .clk(clk), .rst_n(rst_n), .link_ok(link_ok), .rx_pulse(rx_pulse),
        .shift_clk(shift_clk), .status_sdo(status_sdo), .port_led(port_led)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vectors: {link_ok, expected indicator/frame} with no activity
    localparam logic [15:0] VEC [6] = '{
        16'hFF_00, 16'h00_FF, 16'hA5_5A, 16'h0F_F0, 16'h7E_81, 16'hFE_01
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        #1;
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic pulse(input int port);
        rx_pulse[port] = 1'b1;
        step(1);
        rx_pulse = 8'h00;
    endtask

    // Shift one frame; optionally change link_ok after bit 0
    task automatic shift_frame(output logic [7:0] got, input bit mid_change,
                               input logic [7:0] new_link);
        for (int k = 0; k < 8; k++) begin
            shift_clk = 1'b0;
            step(4);
            got[k] = status_sdo;
            if (k == 0 && mid_change) link_ok = new_link;
            shift_clk = 1'b1;
            step(4);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] fr;
        step(3);
        // R9: reset state
        chk("R9 led in reset", port_led, 8'h00);
        chk("R9 sdo in reset", {7'd0, status_sdo}, 8'h00);
        rst_n = 1'b1;
        step(2);

        // R1/R2/R7: static link patterns, indicators and full frames
        foreach (VEC[i]) begin
            link_ok = VEC[i][15:8];
            step(2);
            chk("R1/R2 led pattern", port_led, VEC[i][7:0]);
            shift_frame(fr, 1'b0, 8'h00);
            chk("R7 frame order", fr, VEC[i][7:0]);
        end

        // R3/R4/R5: blink timing on port 3 (N = pulse set cycle)
        link_ok = 8'hFF;
        step(2);
        pulse(3);                               // now N+1
        chk("R3 blink starts", port_led, 8'h08);
        step(4);                                // N+5
        pulse(3);                               // N+6, dropped
        chk("R4 during blink", port_led, 8'h08);
        step(4);                                // N+10
        chk("R3 last blink cycle", port_led, 8'h08);
        step(1);                                // N+11
        chk("R4 blink not extended", port_led, 8'h00);
        step(1);                                // N+12
        pulse(3);                               // N+13, in hold-off
        chk("R4 holdoff dark", port_led, 8'h00);
        step(7);                                // N+20
        chk("R4 holdoff pulse dropped", port_led, 8'h00);
        pulse(3);                               // N+21
        chk("R5 retrigger after holdoff", port_led, 8'h08);
        step(ON_C + OFF_C + 2);

        // R8: snapshot at bit 0; mid-frame link change goes to next frame
        link_ok = 8'hFF;
        step(2);
        shift_frame(fr, 1'b1, 8'h3C);
        chk("R8 frame snapshot", fr, 8'h00);
        shift_frame(fr, 1'b0, 8'h00);
        chk("R8 next frame", fr, 8'hC3);

        // R6/R1: link loss aborts blink, restore then immediate retrigger
        link_ok = 8'hFF;
        step(2);
        pulse(1);
        step(2);
        link_ok[1] = 1'b0;
        pulse(1);
        chk("R1 link fail overrides", port_led, 8'h02);
        link_ok[1] = 1'b1;
        step(1);
        chk("R6 idle after restore", port_led, 8'h00);
        pulse(1);
        chk("R6 immediate retrigger", port_led, 8'h02);

        // R9: reset in the middle of a blink
        rst_n = 1'b0;
        step(2);
        chk("R9 reset clears blink", port_led, 8'h00);
        rst_n = 1'b1;
        step(1);
        pulse(6);
        chk("R9 idle after reset", port_led, 8'h40);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule